// File: doc/BRIEF.md
# Windowed Overlapping Register File

This block is the integer register file of a RISC-style core. Software always sees 32 logical registers. Eight of them are globals that keep the same storage in every context. The other 24 come from a sliding window over a larger physical stack of sixteen registers per window. Two read ports are combinational. One write port updates storage on the rising clock edge. Each port takes a 5-bit logical register number. The window pointer decides which physical entries those numbers reach.

A call strobe moves the window one step down and a return strobe moves it one step up. Neighbouring windows share eight registers, so the caller's outgoing registers become the callee's incoming registers and no data is copied.

A bit mask records which windows are resident. A move into a window that is not resident is refused, and the block raises an overflow pulse (for a call) or an underflow pulse (for a return). Handler logic performs the spill or fill. It then marks the window with the save and restore strobes and retries the move.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 0 to 7 are globals: they reach the same storage whatever the window pointer is.
- R2: A logical register L in 8..31 maps to physical entry 8 + ((cwp*16 + L - 8) mod (NWIN*16)). Logical 8..15 are outgoing, 16..23 are local and 24..31 are incoming. After a call, the callee's registers 24..31 therefore hold the caller's registers 8..15. After the return, the caller's registers 8..15 show what the callee wrote to its registers 24..31.
- R3: The local registers 16..23 of a window are private to it. They keep their values across nested calls and the matching returns.
- R4: Logical register 0 reads as zero on both read ports, and any write to it is discarded.
- R5: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the old value. The two read ports work independently.
- R6: An accepted call sets cwp to cwp-1 mod NWIN, so 0 goes to NWIN-1. An accepted return sets cwp to cwp+1 mod NWIN, so NWIN-1 goes to 0. Each move takes effect at the next clock edge.
- R7: A call whose target window is not resident leaves cwp unchanged. ovf_o is then high for exactly the cycle that follows.
- R8: A return whose target window is not resident leaves cwp unchanged. unf_o is then high for exactly the cycle that follows.
- R9: Reset gives cwp = 0, ovf_o = 0 and unf_o = 0. After reset every window is resident except window 1, which is the return target of window 0.
- R10: save_i marks window win_sel_i as not resident, and restore_i marks it resident. When both strobes name the same window in one cycle, restore wins.
- R11: When call_i and ret_i are high in the same cycle, the call is taken and the return is ignored. No underflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Move window down one step |
| ret_i | input | 1 | Move window up one step |
| save_i | input | 1 | Mark window win_sel_i not resident |
| restore_i | input | 1 | Mark window win_sel_i resident |
| win_sel_i | input | CW | Window selected by save_i / restore_i |
| rd_addr_a_i | input | 5 | Logical address, read port A |
| rd_data_a_o | output | DW | Read data, port A |
| rd_addr_b_i | input | 5 | Logical address, read port B |
| rd_data_b_o | output | DW | Read data, port B |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical write address |
| wr_data_i | input | DW | Write data |
| cwp_o | output | CW | Current window pointer |
| ovf_o | output | 1 | Blocked-call pulse |
| unf_o | output | 1 | Blocked-return pulse |

## Verification
The mapping is first exercised with a scripted call/return sequence. It writes distinct values to outgoing, local, incoming and global registers in different windows, so that a wrong overlap direction, a local shared by mistake, or a global that moves with the pointer each reads back a different value. The pointer is then driven down from window 0, which wraps to the top window, and walked until it reaches the non-resident window, separating the wrap logic from the residency check. Blocked returns, save and restore of single windows, simultaneous strobes, same-cycle write and read, and register 0 each get directed patterns whose expected outputs differ from what the nearest wrong behaviour would give.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int unsigned LREGS = 32;
  localparam int unsigned NGLOB = 8;
  localparam int unsigned WSTEP = 16;
  localparam int unsigned LAW   = $clog2(LREGS);
  typedef logic [LAW-1:0] lreg_t;
endpackage

// File: rtl/rwin_xlate.sv
module rwin_xlate
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3,
  parameter int unsigned PW   = 8
) (
  input  logic [CW-1:0] cwp_i,
  input  lreg_t         lreg_i,
  output logic [PW-1:0] phys_o
);
  localparam int N16 = int'(NWIN * WSTEP);

  int ofs;

  // Outs, locals and ins sit contiguously: ins of window w are outs of w+1.
  always_comb begin
    ofs = int'(cwp_i) * int'(WSTEP) + int'(lreg_i) - int'(NGLOB);
    if (ofs >= N16) ofs = ofs - N16;
    if (int'(lreg_i) < int'(NGLOB)) phys_o = PW'(lreg_i);
    else                            phys_o = PW'(int'(NGLOB) + ofs);
  end
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned CW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic [CW-1:0] win_sel_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  logic [CW-1:0]   cwp_q, tgt_dn, tgt_up;
  logic [NWIN-1:0] valid_q;
  logic            ret_eff, go_dn, go_up;
  logic            ovf_q, unf_q;

  always_comb begin
    tgt_dn  = (cwp_q == '0) ? CW'(NWIN - 1) : cwp_q - CW'(1);
    tgt_up  = (cwp_q == CW'(NWIN - 1)) ? '0 : cwp_q + CW'(1);
    ret_eff = ret_i && !call_i;
    go_dn   = call_i && valid_q[tgt_dn];
    go_up   = ret_eff && valid_q[tgt_up];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (go_dn)      cwp_q <= tgt_dn;
      else if (go_up) cwp_q <= tgt_up;
      ovf_q <= call_i && !valid_q[tgt_dn];
      unf_q <= ret_eff && !valid_q[tgt_up];
    end
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_valid
    localparam logic RST_V = (w != 1);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 valid_q[w] <= RST_V;
      else if (restore_i && win_sel_i == CW'(w))   valid_q[w] <= 1'b1;
      else if (save_i && win_sel_i == CW'(w))      valid_q[w] <= 1'b0;
    end
  end

  assign cwp_o = cwp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NPHYS = 136,
  parameter int unsigned PW    = 8
) (
  input  logic          clk_i,
  input  logic [PW-1:0] raddr_a_i,
  input  logic [PW-1:0] raddr_b_i,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i != '0) mem[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : mem[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : mem[raddr_b_i];
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = $clog2(NWIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          save_i,
  input  logic          restore_i,
  input  logic [CW-1:0] win_sel_i,
  input  logic [4:0]    rd_addr_a_i,
  output logic [DW-1:0] rd_data_a_o,
  input  logic [4:0]    rd_addr_b_i,
  output logic [DW-1:0] rd_data_b_o,
  input  logic          we_i,
  input  logic [4:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [CW-1:0] cwp_o,
  output logic          ovf_o,
  output logic          unf_o
);
  localparam int unsigned NPHYS = NGLOB + NWIN * WSTEP;
  localparam int unsigned PW    = $clog2(NPHYS);
  localparam int unsigned NPORT = 3;

  logic [CW-1:0] cwp;
  lreg_t         laddr [NPORT];
  logic [PW-1:0] paddr [NPORT];

  assign laddr[0] = rd_addr_a_i;
  assign laddr[1] = rd_addr_b_i;
  assign laddr[2] = wr_addr_i;

  rwin_ptr #(.NWIN(NWIN), .CW(CW)) i_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .save_i   (save_i),
    .restore_i(restore_i),
    .win_sel_i(win_sel_i),
    .cwp_o    (cwp),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_xlate
    rwin_xlate #(.NWIN(NWIN), .CW(CW), .PW(PW)) i_xlate (
      .cwp_i (cwp),
      .lreg_i(laddr[p]),
      .phys_o(paddr[p])
    );
  end

  rwin_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) i_store (
    .clk_i    (clk_i),
    .raddr_a_i(paddr[0]),
    .raddr_b_i(paddr[1]),
    .we_i     (we_i),
    .waddr_i  (paddr[2]),
    .wdata_i  (wr_data_i),
    .rdata_a_o(rd_data_a_o),
    .rdata_b_o(rd_data_b_o)
  );

  assign cwp_o = cwp;
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned CW   = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          call_i,
  input logic          ret_i,
  input logic [4:0]    rd_addr_a_i,
  input logic [DW-1:0] rd_data_a_o,
  input logic [4:0]    rd_addr_b_i,
  input logic [DW-1:0] rd_data_b_o,
  input logic [CW-1:0] cwp_o,
  input logic          ovf_o,
  input logic          unf_o
);
  a_r4_zero_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_a_i == '0) |-> (rd_data_a_o == '0));
  a_r4_zero_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_b_i == '0) |-> (rd_data_b_o == '0));
  a_r6_move_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwp_o != $past(cwp_o)) |-> $past(call_i || ret_i));
  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cwp_o != $past(cwp_o)) |->
      ((cwp_o == (($past(cwp_o) == '0) ? CW'(NWIN - 1) : $past(cwp_o) - CW'(1))) ||
       (cwp_o == (($past(cwp_o) == CW'(NWIN - 1)) ? '0 : $past(cwp_o) + CW'(1)))));
  a_r7_ovf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(call_i));
  a_r7_ovf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $stable(cwp_o));
  a_r8_unf_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $past(ret_i && !call_i));
  a_r8_unf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> $stable(cwp_o));
  a_r11_no_both_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));
endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .DW(DW), .CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .rd_addr_a_i(rd_addr_a_i),
  .rd_data_a_o(rd_data_a_o),
  .rd_addr_b_i(rd_addr_b_i),
  .rd_data_b_o(rd_data_b_o),
  .cwp_o      (cwp_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/test_rwin_regfile.sv
module test_rwin_regfile;
  localparam int unsigned NWIN = 8;
  localparam int unsigned DW   = 32;
  localparam int unsigned CW   = 3;
  localparam int NT = 16;
  // kind: 0 write, 1 read-check A, 2 call, 3 return
  localparam logic [38:0] TBL [NT] = '{
    {2'd0, 5'd8,  32'hA1A1_0008},  // caller out r8
    {2'd0, 5'd16, 32'hB0B0_0016},  // caller local
    {2'd0, 5'd1,  32'h6666_0001},  // global
    {2'd2, 5'd0,  32'h0},          // call -> window 7
    {2'd1, 5'd24, 32'hA1A1_0008},  // R2 argument passing
    {2'd0, 5'd16, 32'hB7B7_0016},
    {2'd0, 5'd24, 32'hC7C7_0024},  // return value
    {2'd1, 5'd1,  32'h6666_0001},  // R1 global visible
    {2'd2, 5'd0,  32'h0},          // call -> window 6
    {2'd0, 5'd16, 32'hB6B6_0016},
    {2'd3, 5'd0,  32'h0},          // return -> 7
    {2'd1, 5'd16, 32'hB7B7_0016},  // R3
    {2'd3, 5'd0,  32'h0},          // return -> 0 (wrap)
    {2'd1, 5'd8,  32'hC7C7_0024},  // R2 result back
    {2'd1, 5'd16, 32'hB0B0_0016},  // R3
    {2'd1, 5'd0,  32'h0}           // R4
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          call_i = 1'b0, ret_i = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [CW-1:0] win_sel_i = '0;
  logic [4:0]    rd_addr_a_i = '0, rd_addr_b_i = '0, wr_addr_i = '0;
  logic [DW-1:0] rd_data_a_o, rd_data_b_o, wr_data_i = '0;
  logic          we_i = 1'b0;
  logic [CW-1:0] cwp_o;
  logic          ovf_o, unf_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  rwin_regfile #(.NWIN(NWIN), .DW(DW), .CW(CW)) i_rwin_regfile (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    we_i = 1'b0;
  endtask

  task automatic move(input logic c, input logic r);
    call_i = c; ret_i = r;
    cyc();
    call_i = 1'b0; ret_i = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] a, output logic [31:0] d);
    rd_addr_a_i = a;
    #1 d = rd_data_a_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (2) @(negedge clk_i);
    // R9 reset state
    chk("R9 cwp", 32'(cwp_o), 32'd0);
    chk("R9 ovf", 32'(ovf_o), 32'd0);
    chk("R9 unf", 32'(unf_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NT; i++) begin
      case (TBL[i][38:37])
        2'd0: wr(TBL[i][36:32], TBL[i][31:0]);
        2'd1: begin rd_a(TBL[i][36:32], d); chk($sformatf("R2/R3 table %0d", i), d, TBL[i][31:0]); end
        2'd2: move(1'b1, 1'b0);
        default: move(1'b0, 1'b1);
      endcase
      if (i == 3) chk("R6 call wrap 0->7", 32'(cwp_o), 32'd7);
      if (i == 12) chk("R6 return wrap 7->0", 32'(cwp_o), 32'd0);
    end

    // R4 zero register on both ports
    wr(5'd0, 32'hFFFF_FFFF);
    rd_addr_b_i = 5'd0;
    rd_a(5'd0, d);
    chk("R4 port A", d, 32'h0);
    chk("R4 port B", rd_data_b_o, 32'h0);

    // R5 same-cycle write/read returns old value; ports independent
    wr(5'd9, 32'h1111_0009);
    rd_addr_b_i = 5'd1;
    rd_a(5'd9, d);
    we_i = 1'b1; wr_addr_i = 5'd9; wr_data_i = 32'h2222_0009;
    #1 chk("R5 old value", rd_data_a_o, 32'h1111_0009);
    chk("R5 port B independent", rd_data_b_o, 32'h6666_0001);
    cyc();
    we_i = 1'b0;
    chk("R5 new value", rd_data_a_o, 32'h2222_0009);

    // R8 blocked return from window 0 (window 1 not resident)
    ret_i = 1'b1;
    cyc();
    ret_i = 1'b0;
    chk("R8 unf pulse", 32'(unf_o), 32'd1);
    chk("R8 cwp held", 32'(cwp_o), 32'd0);
    cyc();
    chk("R8 unf one cycle", 32'(unf_o), 32'd0);

    // R6/R7 walk down to window 2 then block
    for (int k = 0; k < 6; k++) move(1'b1, 1'b0);
    chk("R6 cwp after 6 calls", 32'(cwp_o), 32'd2);
    chk("R7 no ovf on resident", 32'(ovf_o), 32'd0);
    call_i = 1'b1;
    cyc();
    call_i = 1'b0;
    chk("R7 ovf pulse", 32'(ovf_o), 32'd1);
    chk("R7 cwp held", 32'(cwp_o), 32'd2);
    cyc();
    chk("R7 ovf one cycle", 32'(ovf_o), 32'd0);

    // R10 restore window 1, retry
    restore_i = 1'b1; win_sel_i = CW'(1);
    cyc();
    restore_i = 1'b0;
    move(1'b1, 1'b0);
    chk("R10 restore allows call", 32'(cwp_o), 32'd1);
    move(1'b0, 1'b1);
    chk("R6 return", 32'(cwp_o), 32'd2);

    // R10 save blocks the call again
    save_i = 1'b1; win_sel_i = CW'(1);
    cyc();
    save_i = 1'b0;
    move(1'b1, 1'b0);
    chk("R10 save blocks call cwp", 32'(cwp_o), 32'd2);
    chk("R10 save blocks call ovf", 32'(ovf_o), 32'd1);

    // R11 both strobes: call wins (blocked here), no underflow
    call_i = 1'b1; ret_i = 1'b1;
    cyc();
    call_i = 1'b0; ret_i = 1'b0;
    chk("R11 ovf", 32'(ovf_o), 32'd1);
    chk("R11 no unf", 32'(unf_o), 32'd0);
    chk("R11 cwp", 32'(cwp_o), 32'd2);

    // R10 save and restore together: restore wins
    save_i = 1'b1; restore_i = 1'b1; win_sel_i = CW'(1);
    cyc();
    save_i = 1'b0; restore_i = 1'b0;
    call_i = 1'b1; ret_i = 1'b1;
    cyc();
    call_i = 1'b0; ret_i = 1'b0;
    chk("R10/R11 call taken", 32'(cwp_o), 32'd1);
    chk("R11 no flags", 32'({ovf_o, unf_o}), 32'd0);

    // R1 global identical in window 1
    rd_a(5'd1, d);
    chk("R1 global in window 1", d, 32'h6666_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule